// File: doc/BRIEF.md
# Redirection-Based Interrupt Router

The router watches a bank of interrupt input lines and turns each pending, unmasked request into one message-signalled write: a 32-bit address word and a 32-bit data word, offered on a valid/ready output. Each pin has a 64-bit redirection entry that sets its vector, delivery mode, destination, destination mode, trigger mode and mask. Software reaches these entries through a plain 32-bit half-entry read/write port.

Edge pins latch a rising edge as a pending request and release it as soon as the message is issued. Level pins follow the input level. When a level pin's message is issued, the router sets that entry's remote-pending flag, and no further message leaves for that pin until an end-of-interrupt carrying the entry's vector clears the flag. Legacy input 0 is folded onto pin 2. When several pins compete, the lowest pin number wins.

Top module: `irq_router`

## Requirements
- R1: After reset, msg_valid is low, and every entry reads back as masked only: the low half is 0x0001_0000 and the high half is 0.
- R2: A request on input 0 is delivered as a request on pin 2. All other inputs map to the pin with the same number.
- R3: An edge-triggered pin (entry bit 15 = 0) with the mask bit (bit 16) set discards a rising edge. Clearing the mask later produces no message.
- R4: A rising edge on an unmasked edge pin produces exactly one message, and its pending state is then cleared.
- R5: When a level pin (bit 15 = 1) is delivered, the entry's remote-pending bit (bit 14) is set. While that bit stays set, the pin sends no further message, even if its input stays high.
- R6: An end-of-interrupt whose vector equals bits 7:0 of a level entry clears that entry's remote-pending bit. If the input is still high, the message is delivered again.
- R7: A masked level pin keeps its pending request and sends it once the mask bit is cleared.
- R8: The message address is 0xFEE0_0000 ORed with the destination (entry bits 63:48) shifted left by 12 and the destination mode (bit 11) placed at address bit 2. Address bits 1:0 and 11:3 are zero.
- R9: The message data carries the vector in bits 7:0, the delivery mode (entry bits 10:8) in bits 10:8 and the trigger mode in bit 15. Every other data bit is zero.
- R10: When several pins are deliverable at once, messages leave in ascending pin order, at most one per accepted transfer.
- R11: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold their values.
- R12: A write cannot change the remote-pending bit. Writing an entry with edge trigger mode clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 24 | Interrupt input levels, indexed by input number |
| tbl_we | input | 1 | Write strobe for the entry half selected by tbl_idx/tbl_hi |
| tbl_idx | input | 5 | Entry index for read and write |
| tbl_hi | input | 1 | 1 selects entry bits 63:32, 0 selects bits 31:0 |
| tbl_wdata | input | 32 | Write data for the selected half |
| tbl_rdata | output | 32 | Selected half of the entry; zero when the index is out of range |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message address word |
| msg_data | output | 32 | Message data word |

## Verification
The assertions assume that the receiver drives msg_ready as a clean level and that reset is held for at least one clock edge. They rely on the design itself for message formatting and do not assume any entry contents. The stimulus changes every input half a cycle away from the active edge. It pulses edge inputs high for exactly one clock and holds level inputs steady across each check window. It also programs an entry only while that pin's input is low, or deliberately masked, so that each expected message is known before it appears.

// File: rtl/irq_router_pkg.sv
// Package: field positions of a redirection entry and the message formatting
// functions shared by the router modules.
// Assumes a 64-bit entry and 32-bit message words.
package irq_router_pkg;

    localparam int ENTRY_W   = 64;
    localparam int VEC_W     = 8;
    localparam int DLV_LSB   = 8;
    localparam int DMODE_BIT = 11;
    localparam int RP_BIT    = 14;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LSB  = 48;
    localparam int DEST_W    = 16;
    localparam int ADDR_DEST_LSB  = 12;
    localparam int ADDR_DMODE_BIT = 2;
    localparam logic [31:0] MSG_BASE    = 32'hFEE0_0000;
    localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

    typedef logic [ENTRY_W-1:0] redir_t;

    // Build the message address word from an entry
    function automatic logic [31:0] fmt_addr(input redir_t e);
        logic [31:0] d;
        logic [31:0] m;
        d = {16'b0, e[DEST_LSB +: DEST_W]} << ADDR_DEST_LSB;
        m = {31'b0, e[DMODE_BIT]} << ADDR_DMODE_BIT;
        return MSG_BASE | d | m;
    endfunction

    // Build the message data word from an entry
    function automatic logic [31:0] fmt_data(input redir_t e);
        return {16'b0, e[TRIG_BIT], 4'b0, e[DLV_LSB +: 3], e[VEC_W-1:0]};
    endfunction

endpackage

// File: rtl/irq_pin_ctrl.sv
// Module: per-pin request latch.
// A level pin tracks its input. An edge pin latches an unmasked rising edge
// and drops it when the top reports the message as issued.
// Assumes the input is already synchronous to clk.
module irq_pin_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic is_level,
    input  logic masked,
    input  logic svc_clr,
    output logic pend
);
    logic prev;

    // Remember last input level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level_in;
    end

    // Pending state update; a new edge wins over a service clear
    always_ff @(posedge clk) begin
        if (!rst_n)                           pend <= 1'b0;
        else if (is_level)                    pend <= level_in;
        else if (level_in && !prev && !masked) pend <= 1'b1;
        else if (svc_clr)                     pend <= 1'b0;
    end
endmodule

// File: rtl/irq_redir_table.sv
// Module: redirection entry storage.
// Half-entry writes keep the remote-pending bit read-only, and an entry
// written as edge-triggered loses that bit. An end-of-interrupt clears the
// bit on matching level entries. Delivery of a level pin sets the bit, and
// this set takes priority.
// Assumes set_rp has at most one bit high.
module irq_redir_table
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 hi,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    input  logic [NUM_PINS-1:0]  set_rp,
    input  logic                 eoi_valid,
    input  logic [VEC_W-1:0]     eoi_vec,
    output redir_t [NUM_PINS-1:0] entries
);
    // Read mux, zero for indices beyond the table
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (idx == IDX_W'(i)) rd_data = hi ? entries[i][63:32] : entries[i][31:0];
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        redir_t nxt;

        // Next value: write, then end-of-interrupt, then delivery
        always_comb begin
            nxt = entries[g];
            if (wr_en && idx == IDX_W'(g)) begin
                if (hi) nxt[63:32] = wr_data;
                else    nxt[31:0]  = wr_data;
                nxt[RP_BIT] = entries[g][RP_BIT] & nxt[TRIG_BIT];
            end
            if (eoi_valid && nxt[TRIG_BIT] && nxt[VEC_W-1:0] == eoi_vec)
                nxt[RP_BIT] = 1'b0;
            if (set_rp[g]) nxt[RP_BIT] = 1'b1;
        end

        // Entry register
        always_ff @(posedge clk) begin
            if (!rst_n) entries[g] <= ENTRY_RESET;
            else        entries[g] <= nxt;
        end
    end
endmodule

// File: rtl/irq_pick.sv
// Module: fixed-priority picker, lowest index wins.
// Purely combinational.
module irq_pick #(
    parameter int N = 24
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Scan upward and keep the first request found
    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_router.sv
// Module: redirection-based interrupt router top.
// Remaps inputs onto pins, keeps per-pin pending state, picks the lowest
// deliverable pin and registers one message at a time on a valid/ready port.
// Assumes NUM_PINS > 2 and irq_in synchronous to clk.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic                tbl_we,
    input  logic [IDX_W-1:0]    tbl_idx,
    input  logic                tbl_hi,
    input  logic [31:0]         tbl_wdata,
    output logic [31:0]         tbl_rdata,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [31:0]         msg_addr,
    output logic [31:0]         msg_data
);
    redir_t [NUM_PINS-1:0] entries;
    logic [NUM_PINS-1:0] pin_lvl, pend, cand, grant, trig, svc_clr, set_rp;
    logic any, fire;
    redir_t sel;

    irq_redir_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .idx(tbl_idx), .hi(tbl_hi),
        .wr_data(tbl_wdata), .rd_data(tbl_rdata), .set_rp(set_rp),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vector), .entries(entries)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        // Input-to-pin map: input 0 folds onto pin 2
        if (g == 0) begin : g_z
            assign pin_lvl[g] = 1'b0;
        end else if (g == 2) begin : g_two
            assign pin_lvl[g] = irq_in[0] | irq_in[2];
        end else begin : g_dir
            assign pin_lvl[g] = irq_in[g];
        end

        assign trig[g] = entries[g][TRIG_BIT];
        // Deliverable: pending, unmasked, and no level delivery outstanding
        assign cand[g] = pend[g] & ~entries[g][MASK_BIT] & ~(trig[g] & entries[g][RP_BIT]);

        irq_pin_ctrl u_pin (
            .clk(clk), .rst_n(rst_n), .level_in(pin_lvl[g]), .is_level(trig[g]),
            .masked(entries[g][MASK_BIT]), .svc_clr(svc_clr[g]), .pend(pend[g])
        );
    end

    irq_pick #(.N(NUM_PINS)) u_pick (.req(cand), .grant(grant), .any(any));

    assign fire    = any & (~msg_valid | msg_ready);
    assign svc_clr = fire ? (grant & ~trig) : '0;
    assign set_rp  = fire ? (grant & trig)  : '0;

    // Select the entry of the granted pin
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_PINS; i++) if (grant[i]) sel = sel | entries[i];
    end

    // Output message register with hold under back-pressure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (fire) begin
            msg_valid <= 1'b1;
            msg_addr  <= fmt_addr(sel);
            msg_data  <= fmt_data(sel);
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_router_chk.sv
// Module: protocol and format checks on the router's message port.
module irq_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [31:0] msg_addr,
    input logic [31:0] msg_data
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !msg_valid);

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R8
    addr_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[1:0] == 2'b0 && msg_addr[11:3] == 9'b0 && msg_addr[31:28] == 4'hF));

    // R9
    data_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:16] == 16'b0 && msg_data[14:11] == 4'b0));
endmodule

bind irq_router irq_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/test_irq_router.sv
module test_irq_router;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [4:0]  src;
        logic [4:0]  pin;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VECS [0:3] = '{
        '{src:5'd1,  pin:5'd1,  lo:32'h0000_0031, hi:32'h0001_0000, addr:32'hFEE0_1000, data:32'h0000_0031},
        '{src:5'd0,  pin:5'd2,  lo:32'h0000_0A45, hi:32'h00FF_0000, addr:32'hFEEF_F004, data:32'h0000_0245},
        '{src:5'd23, pin:5'd23, lo:32'h0000_0720, hi:32'hABCD_0000, addr:32'hFEFC_D000, data:32'h0000_0720},
        '{src:5'd5,  pin:5'd5,  lo:32'h0000_0100, hi:32'h0000_0000, addr:32'hFEE0_0000, data:32'h0000_0100}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [23:0] irq_in = '0;
    logic tbl_we = 1'b0;
    logic [4:0] tbl_idx = '0;
    logic tbl_hi = 1'b0;
    logic [31:0] tbl_wdata = '0;
    logic [31:0] tbl_rdata;
    logic eoi_valid = 1'b0;
    logic [7:0] eoi_vector = '0;
    logic msg_valid;
    logic msg_ready = 1'b0;
    logic [31:0] msg_addr, msg_data;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router i_irq_router (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_hi(tbl_hi), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] idx, input logic hi, input logic [31:0] d);
        tbl_we = 1'b1; tbl_idx = idx; tbl_hi = hi; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] idx, input logic hi, output logic [31:0] v);
        tbl_idx = idx; tbl_hi = hi;
        #1 v = tbl_rdata;
    endtask

    task automatic accept;
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic pulse(input int src);
        irq_in[src] = 1'b1;
        tick(1);
        irq_in[src] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 valid", {31'b0, msg_valid}, 32'h0);
        rd(5'd0, 1'b0, v);  chk("R1 entry0 lo", v, 32'h0001_0000);
        rd(5'd23, 1'b1, v); chk("R1 entry23 hi", v, 32'h0);

        // Table-driven edge deliveries (R2, R4, R8, R9)
        for (int k = 0; k < 4; k++) begin
            wr(VECS[k].pin, 1'b1, VECS[k].hi);
            wr(VECS[k].pin, 1'b0, VECS[k].lo);
            rd(VECS[k].pin, 1'b0, v); chk("R12 readback", v, VECS[k].lo);
            pulse(int'(VECS[k].src));
            tick(1);
            chk(k == 1 ? "R2 valid" : "R4 valid", {31'b0, msg_valid}, 32'h1);
            chk("R8 addr", msg_addr, VECS[k].addr);
            chk("R9 data", msg_data, VECS[k].data);
            accept();
            chk("R4 single", {31'b0, msg_valid}, 32'h0);
            tick(2);
            chk("R4 cleared", {31'b0, msg_valid}, 32'h0);
        end

        // R3 masked edge discarded
        wr(5'd7, 1'b0, 32'h0001_0047);
        pulse(7);
        tick(2);
        chk("R3 masked", {31'b0, msg_valid}, 32'h0);
        wr(5'd7, 1'b0, 32'h0000_0047);
        tick(2);
        chk("R3 unmask", {31'b0, msg_valid}, 32'h0);

        // R5/R6 level with remote-pending
        wr(5'd9, 1'b0, 32'h0000_8050);
        irq_in[9] = 1'b1;
        tick(2);
        chk("R5 valid", {31'b0, msg_valid}, 32'h1);
        chk("R9 level data", msg_data, 32'h0000_8050);
        accept();
        rd(5'd9, 1'b0, v); chk("R5 rp set", v, 32'h0000_C050);
        tick(3);
        chk("R5 suppressed", {31'b0, msg_valid}, 32'h0);
        eoi_valid = 1'b1; eoi_vector = 8'h50;
        tick(1);
        eoi_valid = 1'b0;
        tick(1);
        chk("R6 redeliver", {31'b0, msg_valid}, 32'h1);
        chk("R6 data", msg_data, 32'h0000_8050);
        accept();
        irq_in[9] = 1'b0;
        tick(2);
        // R12 remote-pending read-only, cleared by edge mode
        wr(5'd9, 1'b0, 32'h0000_0050);
        rd(5'd9, 1'b0, v); chk("R12 edge clears", v, 32'h0000_0050);
        wr(5'd9, 1'b0, 32'h0000_C050);
        rd(5'd9, 1'b0, v); chk("R12 read-only", v, 32'h0000_8050);
        tick(2);
        chk("R12 quiet", {31'b0, msg_valid}, 32'h0);

        // R7 masked level keeps pending
        wr(5'd10, 1'b0, 32'h0001_8060);
        irq_in[10] = 1'b1;
        tick(3);
        chk("R7 masked", {31'b0, msg_valid}, 32'h0);
        wr(5'd10, 1'b0, 32'h0000_8060);
        tick(1);
        chk("R7 valid", {31'b0, msg_valid}, 32'h1);
        chk("R7 data", msg_data, 32'h0000_8060);
        accept();
        irq_in[10] = 1'b0;
        eoi_valid = 1'b1; eoi_vector = 8'h60;
        tick(1);
        eoi_valid = 1'b0;
        tick(2);
        chk("R6 no redeliver", {31'b0, msg_valid}, 32'h0);

        // R10/R11 ordering and hold
        wr(5'd3, 1'b0, 32'h0000_0033);
        wr(5'd4, 1'b0, 32'h0000_0034);
        irq_in[3] = 1'b1; irq_in[4] = 1'b1;
        tick(1);
        irq_in[3] = 1'b0; irq_in[4] = 1'b0;
        tick(1);
        chk("R10 first", msg_data, 32'h0000_0033);
        tick(3);
        chk("R11 hold valid", {31'b0, msg_valid}, 32'h1);
        chk("R11 hold data", msg_data, 32'h0000_0033);
        accept();
        chk("R10 second valid", {31'b0, msg_valid}, 32'h1);
        chk("R10 second", msg_data, 32'h0000_0034);
        accept();
        chk("R10 drained", {31'b0, msg_valid}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule